// File: doc/BRIEF.md
# PLL Power Sequencer

This block steps a clock synthesizer out of its powered-down, isolated state into a running, enabled state with its reset released. It also takes the synthesizer back down again. A one-cycle pulse on `prep_req` starts the power-up walk. Power is applied first. After a short settle time, the isolation clamp is lifted. After another short settle, the configured enable bits are written into the control word and the tuner is switched on. A long settle follows, and then the active-low reset release bits are set.

A pulse on `unprep_req` undoes these steps in the opposite order. The steps run on consecutive clock cycles with no waits between them.

All wait lengths are whole microseconds, converted to clock cycles through the `TICKS_PER_US` parameter. The tuner and the reset-release stage are each optional, selected by a parameter. When a stage is absent, its steps are skipped.

A request that arrives while a walk is in progress is held and acted on once the walk ends. Only the most recent held request is kept.

Top module: `pll_pwr_seq`

## Requirements
- R1: After reset, `pwr_on`=0, `iso_en`=1, `ctrl_reg`=0, `tuner_en`=0 and `prepared`=0.
- R2: On a prepare request from the powered-down state, `pwr_on` rises first, and `iso_en` falls exactly SHORT_US*TICKS_PER_US cycles later.
- R3: Exactly SHORT_US*TICKS_PER_US cycles after `iso_en` falls, every bit of EN_MASK (which includes bit 0) is set in `ctrl_reg`. When the tuner is present, `tuner_en` rises in the same cycle.
- R4: Exactly LONG_US*TICKS_PER_US cycles after the enable bits are set, the bits of RST_MASK are set in `ctrl_reg` (reset-release stage present). Those bits are never set while `prepared` is 0.
- R5: `prepared` always equals bit 0 of `ctrl_reg`.
- R6: On an unprepare request from the prepared state, the following happens on five consecutive cycles, in this order: the RST_MASK bits clear, `tuner_en` clears, bit 0 of `ctrl_reg` clears, `iso_en` sets, and `pwr_on` clears.
- R7: Unprepare clears only bit 0 of the enable mask. All other EN_MASK bits remain set in `ctrl_reg`.
- R8: A request that arrives during a walk is held until the walk ends and is then acted on. If several requests arrive, only the most recent one is kept.
- R9: A prepare request while prepared, and an unprepare request while not prepared, leave every output unchanged.
- R10: `iso_en` is low only while `pwr_on` is high. Power is removed only after isolation has been set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prep_req | input | 1 | One-cycle request to power up |
| unprep_req | input | 1 | One-cycle request to power down |
| pwr_on | output | 1 | Power-register power-on bit |
| iso_en | output | 1 | Power-register isolation bit |
| ctrl_reg | output | CTRL_W | Control word with enable and reset-release bits |
| tuner_en | output | 1 | Tuner enable bit |
| prepared | output | 1 | Enabled status, equal to control bit 0 |

## Verification
The hardest situation to reach from the ports is a request that lands while a walk is still in progress. There is also the case of an older held request being overwritten by a newer one before the walk ends. The stimulus issues a prepare pulse and then, while the long settle is still counting, an unprepare pulse. The power-up is expected to finish with its full timing, after which the power-down runs. A second run issues an unprepare and then a prepare during the long settle. The newer prepare should replace the held unprepare and then be ignored, because the block is already prepared by the time the walk ends.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UP_PWR,
    ST_UP_W1,
    ST_UP_W2,
    ST_UP_W3,
    ST_DN_RST,
    ST_DN_TUN,
    ST_DN_EN,
    ST_DN_ISO,
    ST_DN_PWR
  } seq_state_e;

  typedef enum logic [3:0] {
    ACT_NONE,
    ACT_PWR_ON,
    ACT_ISO_OFF,
    ACT_ENABLE,
    ACT_RST_REL,
    ACT_RST_HOLD,
    ACT_TUN_OFF,
    ACT_DISABLE,
    ACT_ISO_ON,
    ACT_PWR_OFF
  } seq_act_e;

  typedef enum logic [1:0] {
    REQ_NONE,
    REQ_UP,
    REQ_DN
  } req_kind_e;

endpackage

// File: rtl/pll_seq_req.sv
module pll_seq_req
  import pll_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      prep_req,
  input  logic      unprep_req,
  input  logic      take,
  output req_kind_e pend
);

  // Single slot: the newest request overwrites any older one (R8).
  always_ff @(posedge clk) begin
    if (rst)             pend <= REQ_NONE;
    else if (prep_req)   pend <= REQ_UP;
    else if (unprep_req) pend <= REQ_DN;
    else if (take)       pend <= REQ_NONE;
  end

endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int TICKS_PER_US = 4,
  parameter int SHORT_US     = 1,
  parameter int LONG_US      = 20,
  parameter bit HAS_TUNER    = 1'b1,
  parameter bit HAS_RSTB     = 1'b1,
  parameter int CNT_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  req_kind_e        pend,
  input  logic             prepared,
  input  logic             tmr_done,
  output logic             take,
  output seq_act_e         act,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  localparam int W_SHORT = SHORT_US * TICKS_PER_US;
  localparam int W_LONG  = LONG_US * TICKS_PER_US;

  // Entry into the shutdown chain skips stages that are not built.
  localparam seq_state_e DN_FIRST  = HAS_RSTB  ? ST_DN_RST :
                                     (HAS_TUNER ? ST_DN_TUN : ST_DN_EN);
  localparam seq_state_e AFTER_RST = HAS_TUNER ? ST_DN_TUN : ST_DN_EN;
  localparam seq_act_e   LAST_UP   = HAS_RSTB  ? ACT_RST_REL : ACT_NONE;

  seq_state_e st, nxt;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= nxt;
  end

  // A wait state fires the following step itself once the count runs out,
  // so the gap between two steps is exactly the programmed cycle count.
  always_comb begin
    nxt      = st;
    act      = ACT_NONE;
    tmr_load = 1'b0;
    tmr_val  = '0;
    take     = 1'b0;
    unique case (st)
      ST_IDLE: begin
        take = 1'b1;
        if (pend == REQ_UP && !prepared)     nxt = ST_UP_PWR;
        else if (pend == REQ_DN && prepared) nxt = DN_FIRST;
      end
      ST_UP_PWR: begin
        act      = ACT_PWR_ON;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(W_SHORT - 1);
        nxt      = ST_UP_W1;
      end
      ST_UP_W1: begin
        if (tmr_done) begin
          act      = ACT_ISO_OFF;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(W_SHORT - 1);
          nxt      = ST_UP_W2;
        end
      end
      ST_UP_W2: begin
        if (tmr_done) begin
          act      = ACT_ENABLE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(W_LONG - 1);
          nxt      = ST_UP_W3;
        end
      end
      ST_UP_W3: begin
        if (tmr_done) begin
          act = LAST_UP;
          nxt = ST_IDLE;
        end
      end
      ST_DN_RST: begin
        act = ACT_RST_HOLD;
        nxt = AFTER_RST;
      end
      ST_DN_TUN: begin
        act = ACT_TUN_OFF;
        nxt = ST_DN_EN;
      end
      ST_DN_EN: begin
        act = ACT_DISABLE;
        nxt = ST_DN_ISO;
      end
      ST_DN_ISO: begin
        act = ACT_ISO_ON;
        nxt = ST_DN_PWR;
      end
      ST_DN_PWR: begin
        act = ACT_PWR_OFF;
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/pll_seq_regs.sv
module pll_seq_regs
  import pll_seq_pkg::*;
#(
  parameter int              CTRL_W    = 32,
  parameter logic [CTRL_W-1:0] EN_MASK  = CTRL_W'(32'h0000_0011),
  parameter logic [CTRL_W-1:0] RST_MASK = CTRL_W'(32'h0080_0000),
  parameter bit              HAS_TUNER = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_act_e          act,
  output logic              pwr_on,
  output logic              iso_en,
  output logic [CTRL_W-1:0] ctrl_reg,
  output logic              tuner_en,
  output logic              prepared
);

  localparam logic [CTRL_W-1:0] BIT0 = CTRL_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_on   <= 1'b0;
      iso_en   <= 1'b1;
      ctrl_reg <= '0;
      prepared <= 1'b0;
    end else begin
      case (act)
        ACT_PWR_ON:   pwr_on <= 1'b1;
        ACT_ISO_OFF:  iso_en <= 1'b0;
        ACT_ENABLE: begin
          ctrl_reg <= ctrl_reg | EN_MASK;
          prepared <= EN_MASK[0];
        end
        ACT_RST_REL:  ctrl_reg <= ctrl_reg | RST_MASK;
        ACT_RST_HOLD: ctrl_reg <= ctrl_reg & ~RST_MASK;
        ACT_DISABLE: begin
          ctrl_reg <= ctrl_reg & ~BIT0;
          prepared <= 1'b0;
        end
        ACT_ISO_ON:   iso_en <= 1'b1;
        ACT_PWR_OFF:  pwr_on <= 1'b0;
        default: ;
      endcase
    end
  end

  generate
    if (HAS_TUNER) begin : g_tuner
      always_ff @(posedge clk) begin
        if (rst)                      tuner_en <= 1'b0;
        else if (act == ACT_ENABLE)   tuner_en <= 1'b1;
        else if (act == ACT_TUN_OFF)  tuner_en <= 1'b0;
      end
    end else begin : g_no_tuner
      assign tuner_en = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
  import pll_seq_pkg::*;
#(
  parameter int                TICKS_PER_US = 4,
  parameter int                SHORT_US     = 1,
  parameter int                LONG_US      = 20,
  parameter int                CTRL_W       = 32,
  parameter logic [CTRL_W-1:0] EN_MASK      = CTRL_W'(32'h0000_0011),
  parameter logic [CTRL_W-1:0] RST_MASK     = CTRL_W'(32'h0080_0000),
  parameter bit                HAS_TUNER    = 1'b1,
  parameter bit                HAS_RSTB     = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prep_req,
  input  logic              unprep_req,
  output logic              pwr_on,
  output logic              iso_en,
  output logic [CTRL_W-1:0] ctrl_reg,
  output logic              tuner_en,
  output logic              prepared
);

  localparam int W_LONG = LONG_US * TICKS_PER_US;
  localparam int CNT_W  = $clog2(W_LONG + 1);

  req_kind_e        pend;
  logic             take;
  seq_act_e         act;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;

  pll_seq_req u_req (
    .clk        (clk),
    .rst        (rst),
    .prep_req   (prep_req),
    .unprep_req (unprep_req),
    .take       (take),
    .pend       (pend)
  );

  pll_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  pll_seq_fsm #(
    .TICKS_PER_US (TICKS_PER_US),
    .SHORT_US     (SHORT_US),
    .LONG_US      (LONG_US),
    .HAS_TUNER    (HAS_TUNER),
    .HAS_RSTB     (HAS_RSTB),
    .CNT_W        (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .pend     (pend),
    .prepared (prepared),
    .tmr_done (tmr_done),
    .take     (take),
    .act      (act),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val)
  );

  pll_seq_regs #(
    .CTRL_W    (CTRL_W),
    .EN_MASK   (EN_MASK),
    .RST_MASK  (RST_MASK),
    .HAS_TUNER (HAS_TUNER)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .pwr_on   (pwr_on),
    .iso_en   (iso_en),
    .ctrl_reg (ctrl_reg),
    .tuner_en (tuner_en),
    .prepared (prepared)
  );

endmodule

// File: rtl/pll_pwr_seq_chk.sv
module pll_pwr_seq_chk #(
  parameter int                CTRL_W   = 32,
  parameter logic [CTRL_W-1:0] RST_MASK = CTRL_W'(32'h0080_0000)
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_on,
  input logic              iso_en,
  input logic [CTRL_W-1:0] ctrl_reg,
  input logic              tuner_en,
  input logic              prepared
);

  a_r5_status_bit0: assert property (@(posedge clk) disable iff (rst)
    prepared == ctrl_reg[0]);

  a_r10_iso_needs_power: assert property (@(posedge clk) disable iff (rst)
    !iso_en |-> pwr_on);

  a_r2_power_before_iso: assert property (@(posedge clk) disable iff (rst)
    $fell(iso_en) |-> (pwr_on && $past(pwr_on)));

  a_r10_iso_before_power_off: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_on) |-> (iso_en && $past(iso_en)));

  a_r3_enable_after_iso: assert property (@(posedge clk) disable iff (rst)
    $rose(prepared) |-> !iso_en);

  a_r4_release_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (|(ctrl_reg & RST_MASK)) |-> prepared);

  a_r6_tuner_off_before_disable: assert property (@(posedge clk) disable iff (rst)
    $fell(prepared) |-> !tuner_en);

endmodule

bind pll_pwr_seq pll_pwr_seq_chk #(
  .CTRL_W   (CTRL_W),
  .RST_MASK (RST_MASK)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pwr_on   (pwr_on),
  .iso_en   (iso_en),
  .ctrl_reg (ctrl_reg),
  .tuner_en (tuner_en),
  .prepared (prepared)
);

// File: tb/pll_pwr_seq_tb.sv
module pll_pwr_seq_tb;

  localparam int          CLK_PERIOD = 10;
  localparam int          TICKS      = 4;
  localparam int          W_SHORT    = 1 * TICKS;
  localparam int          W_LONG     = 20 * TICKS;
  localparam logic [31:0] EN_M       = 32'h0000_0011;
  localparam logic [31:0] RST_M      = 32'h0080_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prep_req = 1'b0;
  logic        unprep_req = 1'b0;
  logic        pwr_on, iso_en, tuner_en, prepared;
  logic [31:0] ctrl_reg;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  int t_pwr_up, t_iso_dn, t_en_up, t_tun_up, t_rst_up;
  int t_rst_dn, t_tun_dn, t_en_dn, t_iso_up, t_pwr_dn;
  logic pwr_q, iso_q, en_q, tun_q, rs_q;
  bit   r5_bad = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_pwr_seq #(
    .TICKS_PER_US (TICKS),
    .CTRL_W       (32),
    .EN_MASK      (EN_M),
    .RST_MASK     (RST_M),
    .HAS_TUNER    (1'b1),
    .HAS_RSTB     (1'b1)
  ) u_dut (
    .clk        (clk),
    .rst        (rst),
    .prep_req   (prep_req),
    .unprep_req (unprep_req),
    .pwr_on     (pwr_on),
    .iso_en     (iso_en),
    .ctrl_reg   (ctrl_reg),
    .tuner_en   (tuner_en),
    .prepared   (prepared)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Edge timestamps, sampled between clock edges.
  always @(negedge clk) begin
    logic rs;
    rs = |(ctrl_reg & RST_M);
    if (!rst) begin
      if (pwr_on && !pwr_q)        t_pwr_up = cyc;
      if (!pwr_on && pwr_q)        t_pwr_dn = cyc;
      if (!iso_en && iso_q)        t_iso_dn = cyc;
      if (iso_en && !iso_q)        t_iso_up = cyc;
      if (ctrl_reg[0] && !en_q)    t_en_up = cyc;
      if (!ctrl_reg[0] && en_q)    t_en_dn = cyc;
      if (tuner_en && !tun_q)      t_tun_up = cyc;
      if (!tuner_en && tun_q)      t_tun_dn = cyc;
      if (rs && !rs_q)             t_rst_up = cyc;
      if (!rs && rs_q)             t_rst_dn = cyc;
      if (prepared !== ctrl_reg[0]) r5_bad = 1'b1;
    end
    pwr_q = pwr_on; iso_q = iso_en; en_q = ctrl_reg[0];
    tun_q = tuner_en; rs_q = rs;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act_v, input logic [31:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act_v, exp_v);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic pulse(input bit up);
    @(negedge clk);
    if (up) prep_req = 1'b1; else unprep_req = 1'b1;
    @(negedge clk);
    prep_req = 1'b0; unprep_req = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic test_reset();
    chk(pwr_on == 1'b0,    "R1", "pwr_on",   pwr_on, 0);
    chk(iso_en == 1'b1,    "R1", "iso_en",   iso_en, 1);
    chk(ctrl_reg == '0,    "R1", "ctrl_reg", ctrl_reg, 0);
    chk(tuner_en == 1'b0,  "R1", "tuner_en", tuner_en, 0);
    chk(prepared == 1'b0,  "R1", "prepared", prepared, 0);
  endtask

  task automatic test_prepare(input logic [31:0] exp_ctrl);
    pulse(1'b1);
    wait_cyc(W_SHORT + W_SHORT + W_LONG + 10);
    chk(t_iso_dn - t_pwr_up == W_SHORT, "R2", "pwr->iso gap",
        t_iso_dn - t_pwr_up, W_SHORT);
    chk(t_en_up - t_iso_dn == W_SHORT, "R3", "iso->enable gap",
        t_en_up - t_iso_dn, W_SHORT);
    chk(t_tun_up == t_en_up, "R3", "tuner with enable", t_tun_up, t_en_up);
    chk(t_rst_up - t_en_up == W_LONG, "R4", "enable->release gap",
        t_rst_up - t_en_up, W_LONG);
    chk(ctrl_reg == exp_ctrl, "R3", "ctrl after prepare", ctrl_reg, exp_ctrl);
    chk(prepared && pwr_on && !iso_en && tuner_en, "R5", "status up",
        {pwr_on, iso_en, tuner_en, prepared}, 4'b1011);
  endtask

  task automatic test_unprepare();
    pulse(1'b0);
    wait_cyc(12);
    chk(t_tun_dn - t_rst_dn == 1, "R6", "release->tuner", t_tun_dn - t_rst_dn, 1);
    chk(t_en_dn - t_tun_dn == 1,  "R6", "tuner->disable", t_en_dn - t_tun_dn, 1);
    chk(t_iso_up - t_en_dn == 1,  "R6", "disable->iso",   t_iso_up - t_en_dn, 1);
    chk(t_pwr_dn - t_iso_up == 1, "R6", "iso->power off", t_pwr_dn - t_iso_up, 1);
    chk(ctrl_reg == (EN_M & ~32'h1), "R7", "enable bits kept", ctrl_reg,
        EN_M & ~32'h1);
    chk(!prepared && !pwr_on && iso_en && !tuner_en, "R6", "status down",
        {pwr_on, iso_en, tuner_en, prepared}, 4'b0100);
  endtask

  task automatic test_ignore_prepare();
    logic [31:0] c0;
    int tp;
    c0 = ctrl_reg; tp = t_pwr_up;
    pulse(1'b1);
    wait_cyc(W_LONG + 20);
    chk(ctrl_reg == c0 && prepared && pwr_on && !iso_en && tuner_en,
        "R9", "prepare while prepared", ctrl_reg, c0);
    chk(t_pwr_up == tp, "R9", "no new power edge", t_pwr_up, tp);
  endtask

  task automatic test_ignore_unprepare();
    logic [31:0] c0;
    c0 = ctrl_reg;
    pulse(1'b0);
    wait_cyc(20);
    chk(ctrl_reg == c0 && !prepared && !pwr_on && iso_en && !tuner_en,
        "R9", "unprepare while down", ctrl_reg, c0);
  endtask

  task automatic test_held();
    // Unprepare issued during the long settle: held, then executed.
    pulse(1'b1);
    wait_cyc(2 * W_SHORT + 6);
    pulse(1'b0);
    wait_cyc(W_LONG + 20);
    chk(t_rst_up - t_en_up == W_LONG, "R8", "up walk completed",
        t_rst_up - t_en_up, W_LONG);
    chk(t_pwr_dn > t_rst_up, "R8", "held unprepare ran after", t_pwr_dn, t_rst_up);
    chk(!prepared && !pwr_on && iso_en, "R8", "ends down",
        {pwr_on, iso_en, prepared}, 3'b010);
    // Unprepare then prepare during the walk: the later prepare wins.
    pulse(1'b1);
    wait_cyc(2 * W_SHORT + 6);
    pulse(1'b0);
    pulse(1'b1);
    wait_cyc(W_LONG + 20);
    chk(prepared && pwr_on && !iso_en, "R8", "newest request kept",
        {pwr_on, iso_en, prepared}, 3'b101);
    chk(t_pwr_dn < t_pwr_up, "R8", "no power-down ran", t_pwr_dn, t_pwr_up);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_prepare(EN_M | RST_M);
    test_ignore_prepare();
    test_unprepare();
    test_ignore_unprepare();
    test_prepare(EN_M | RST_M);
    test_unprepare();
    test_held();
    chk(!r5_bad, "R5", "status tracks bit0", r5_bad, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog run did not end actual=%0d expected=<100000", cyc);
    summary();
    $finish;
  end

endmodule